// File: doc/BRIEF.md
# Block-Averaged Signal Power Meter

This block estimates the mean power of one component of a two-channel complex sample stream. Software picks the tap (the datapath's input samples or its output samples) and the channel. It also sets how many fixed-size blocks of samples the estimate spans. For every qualified sample the block forms I squared plus Q squared and adds it into a wide accumulator. When the last sample of the last block arrives, it divides the total by the exact number of samples taken. The upper 16 bits of the 32-bit average go into a read-only result register.

There is no start bit. Writing the control register with a non-zero block count starts a measurement at once. A later write to the same register abandons any measurement in progress and starts over with the new settings. When a measurement completes, the block-count field returns to zero and a sticky completion flag is set. That flag drives the interrupt output only while bit 5 of the interrupt mask register is set.

Software uses a small word-wide register port. It is write-strobed, and reads are combinational on the address. Address 0 is control, address 1 is block length, address 2 is the result and address 3 is the interrupt mask.

Top module: `pm_power_meter`

## Requirements
- R1: After reset, control reads 0x0000, block length reads 0xFFFF, result reads 0x0000, the mask reads 0x0000, irq is low, and no measurement runs.
- R2: A control write (address 0) whose bits [13:0] are non-zero starts a measurement with that many blocks. A control write whose bits [13:0] are zero starts nothing, and later samples leave the result unchanged.
- R3: Control bit 14 selects the tap. 0 takes samples from in_i/in_q qualified by in_vld. 1 takes samples from out_i/out_q qualified by out_vld. The other tap is ignored.
- R4: Control bit 15 selects the channel, 0 or 1. Samples on the other channel are ignored.
- R5: The block-length register (address 1) holds N-1 for N samples per block. A measurement takes exactly count×N qualified samples, and cycles where the selected valid is low are not counted.
- R6: The result (address 2) is floor(sum of (I²+Q²) / total samples) shifted right by 16. A full-scale input of I = Q = -32768 yields 0x8000 without overflow.
- R7: On completion, control bits [13:0] become zero while bits 15:14 keep their value. Samples that arrive afterwards do not change the result.
- R8: Completion sets a sticky flag, and irq equals that flag ANDed with mask bit 5. Other mask bits do not drive irq. Any control write clears the flag.
- R9: A control write during a running measurement discards it. The result then reflects only the samples taken under the new settings, and only one completion follows.
- R10: A write to the result address is ignored. Block length and mask read back the value written.
- R11: The result register changes only in the cycle a measurement completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for addr |
| in_vld | input | 1 | Input-tap sample qualifier |
| in_i | input | 2x16 | Input-tap in-phase samples, one per channel, signed |
| in_q | input | 2x16 | Input-tap quadrature samples, one per channel, signed |
| out_vld | input | 1 | Output-tap sample qualifier |
| out_i | input | 2x16 | Output-tap in-phase samples, one per channel, signed |
| out_q | input | 2x16 | Output-tap quadrature samples, one per channel, signed |
| irq | output | 1 | Completion interrupt, gated by mask bit 5 |

## Verification
Faults in the block counter, sample counter or accumulator show up in two ways. The completion interrupt arrives after too many or too few qualified samples, or the result word is off. A miscount that stops completion entirely leaves irq low forever. Feeding exact sample counts with the other tap, channel and invalid cycles all carrying large values exposes selection or qualification errors as a large result error. That error is visible about 65 cycles after the last sample, once the serial division ends. A corrupted done flag or mask gate shows at irq within one cycle of the completion or the register write.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_BLKLEN = 2'd1;
    localparam logic [ADDR_W-1:0] A_RESULT = 2'd2;
    localparam logic [ADDR_W-1:0] A_IMASK  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DIV  = 2'd2
    } meas_st_e;

endpackage

// File: rtl/pm_power_calc.sv
module pm_power_calc #(
    parameter int SW  = 16,
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PW  = 2 * SW
) (
    input  logic                    tap_sel,
    input  logic [CHW-1:0]          ch_sel,
    input  logic                    in_vld,
    input  logic [NCH-1:0][SW-1:0]  in_i,
    input  logic [NCH-1:0][SW-1:0]  in_q,
    input  logic                    out_vld,
    input  logic [NCH-1:0][SW-1:0]  out_i,
    input  logic [NCH-1:0][SW-1:0]  out_q,
    output logic                    pwr_vld,
    output logic [PW-1:0]           pwr
);

    logic signed [SW-1:0] tap_i [NCH];
    logic signed [SW-1:0] tap_q [NCH];

    // per-channel tap choice
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign tap_i[c] = tap_sel ? out_i[c] : in_i[c];
        assign tap_q[c] = tap_sel ? out_q[c] : in_q[c];
    end

    logic signed [PW-1:0] ext_i, ext_q;
    logic signed [PW-1:0] sq_i, sq_q;

    always_comb begin
        ext_i   = PW'(tap_i[ch_sel]);
        ext_q   = PW'(tap_q[ch_sel]);
        sq_i    = ext_i * ext_i;
        sq_q    = ext_q * ext_q;
        pwr     = $unsigned(sq_i) + $unsigned(sq_q);
        pwr_vld = tap_sel ? out_vld : in_vld;
    end

endmodule

// File: rtl/pm_divider.sv
module pm_divider #(
    parameter int NW = 62,
    parameter int DW = 30,
    parameter int QW = 16,
    parameter int SH = 16,
    localparam int CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [NW-1:0] num;
        logic [NW-1:0] quo;
        logic [DW-1:0] rem;
        logic [DW-1:0] dvs;
    } div_t;

    div_t q, d;
    logic [DW:0] trial;
    logic [DW:0] diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.num[NW-1]};
        diff   = trial - {1'b0, q.dvs};
        if (abort) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(NW);
            d.num  = dividend;
            d.quo  = '0;
            d.rem  = '0;
            d.dvs  = divisor;
        end else if (q.busy) begin
            d.num = q.num << 1;
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = diff[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b1};
            end else begin
                d.rem = trial[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b0};
            end
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign quotient = q.quo[SH +: QW];

endmodule

// File: rtl/pm_power_meter.sv
module pm_power_meter
    import pm_pkg::*;
#(
    parameter int SW      = 16,
    parameter int NCH     = 2,
    parameter int REGW    = 16,
    parameter int IRQ_BIT = 5,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNTW = REGW - 1 - CHW,
    localparam int TAPB = CNTW,
    localparam int CHB  = CNTW + 1,
    localparam int PW   = 2 * SW,
    localparam int TOTW = CNTW + REGW,
    localparam int ACCW = PW + TOTW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REGW-1:0]        wdata,
    output logic [REGW-1:0]        rdata,
    input  logic                   in_vld,
    input  logic [NCH-1:0][SW-1:0] in_i,
    input  logic [NCH-1:0][SW-1:0] in_q,
    input  logic                   out_vld,
    input  logic [NCH-1:0][SW-1:0] out_i,
    input  logic [NCH-1:0][SW-1:0] out_q,
    output logic                   irq
);

    typedef struct packed {
        meas_st_e        st;
        logic [REGW-1:0] ctrl;
        logic [REGW-1:0] len;
        logic [REGW-1:0] mask;
        logic [REGW-1:0] result;
        logic            done;
        logic [ACCW-1:0] sum;
        logic [CNTW-1:0] blk;
        logic [REGW-1:0] smp;
    } meter_t;

    meter_t q, d;

    logic            pwr_vld;
    logic [PW-1:0]   pwr;
    logic            ctrl_wr;
    logic            div_start;
    logic            div_abort;
    logic            div_done;
    logic [REGW-1:0] div_res;
    logic [ACCW-1:0] sum_nx;
    logic [TOTW-1:0] total;

    pm_power_calc #(.SW(SW), .NCH(NCH)) u_calc (
        .tap_sel (q.ctrl[TAPB]),
        .ch_sel  (q.ctrl[CHB +: CHW]),
        .in_vld  (in_vld),
        .in_i    (in_i),
        .in_q    (in_q),
        .out_vld (out_vld),
        .out_i   (out_i),
        .out_q   (out_q),
        .pwr_vld (pwr_vld),
        .pwr     (pwr)
    );

    pm_divider #(.NW(ACCW), .DW(TOTW), .QW(REGW), .SH(PW - REGW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .abort    (div_abort),
        .dividend (sum_nx),
        .divisor  (total),
        .done     (div_done),
        .quotient (div_res)
    );

    always_comb begin
        d         = q;
        div_start = 1'b0;
        div_abort = 1'b0;
        ctrl_wr   = wr_en && (addr == A_CTRL);
        sum_nx    = q.sum + ACCW'(pwr);
        total     = TOTW'(q.ctrl[CNTW-1:0]) * (TOTW'(q.len) + TOTW'(1));

        // accumulate qualified samples, close blocks
        if (q.st == ST_ACC && pwr_vld) begin
            d.sum = sum_nx;
            if (q.smp == q.len) begin
                d.smp = '0;
                if (q.blk + CNTW'(1) == q.ctrl[CNTW-1:0]) begin
                    div_start = 1'b1;
                    d.st      = ST_DIV;
                end else begin
                    d.blk = q.blk + CNTW'(1);
                end
            end else begin
                d.smp = q.smp + REGW'(1);
            end
        end

        // completion
        if (q.st == ST_DIV && div_done && !ctrl_wr) begin
            d.result           = div_res;
            d.done             = 1'b1;
            d.ctrl[CNTW-1:0]   = '0;
            d.st               = ST_IDLE;
        end

        // register writes
        if (ctrl_wr) begin
            d.ctrl    = wdata;
            d.done    = 1'b0;
            d.sum     = '0;
            d.blk     = '0;
            d.smp     = '0;
            div_abort = 1'b1;
            div_start = 1'b0;
            d.st      = (wdata[CNTW-1:0] != '0) ? ST_ACC : ST_IDLE;
        end
        if (wr_en && addr == A_BLKLEN) d.len  = wdata;
        if (wr_en && addr == A_IMASK)  d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.len <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:   rdata = q.ctrl;
            A_BLKLEN: rdata = q.len;
            A_RESULT: rdata = q.result;
            default:  rdata = q.mask;
        endcase
    end

    assign irq = q.done & q.mask[IRQ_BIT];

endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pm_pkg::*;
#(
    parameter int REGW    = 16,
    parameter int CNTW    = 14,
    parameter int IRQ_BIT = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic            ctrl_wr,
    input meas_st_e        st,
    input logic [REGW-1:0] ctrl,
    input logic [REGW-1:0] mask,
    input logic [REGW-1:0] result,
    input logic            done,
    input logic [CNTW-1:0] blk,
    input logic [REGW-1:0] smp,
    input logic            div_done
);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && mask[IRQ_BIT]));  // R8

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ctrl_wr) |=> (st == ST_IDLE));  // R2

    AST_BLK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACC) |-> (blk < ctrl[CNTW-1:0]));  // R5

    AST_CLEAR_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DIV && div_done && !ctrl_wr) |=> (ctrl[CNTW-1:0] == '0 && done));  // R7

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (blk == '0 && smp == '0 && !done));  // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !div_done |=> $stable(result));  // R11

endmodule

bind pm_power_meter pm_checker #(.REGW(REGW), .CNTW(CNTW), .IRQ_BIT(IRQ_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .ctrl_wr  (ctrl_wr),
    .st       (q.st),
    .ctrl     (q.ctrl),
    .mask     (q.mask),
    .result   (q.result),
    .done     (q.done),
    .blk      (q.blk),
    .smp      (q.smp),
    .div_done (div_done)
);

// File: tb/tb_pm_power_meter.sv
`timescale 1ns/1ps
module tb_pm_power_meter;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        addr = 2'd2;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              in_vld = 1'b0;
    logic [1:0][15:0]  in_i = '0, in_q = '0;
    logic              out_vld = 1'b0;
    logic [1:0][15:0]  out_i = '0, out_q = '0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    longint exp_sum = 0;
    longint exp_n   = 0;
    logic [15:0] expq[$];
    logic [15:0] rv;

    always #4 clk = ~clk;

    pm_power_meter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .out_vld(out_vld), .out_i(out_i), .out_q(out_q), .irq(irq)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd2;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
        addr = 2'd2;
        @(negedge clk);
    endtask

    task automatic start_meas(input logic [15:0] c);
        exp_sum = 0;
        exp_n   = 0;
        wr(2'd0, c);
    endtask

    task automatic idle();
        in_vld = 1'b0;
        out_vld = 1'b0;
    endtask

    // drive one cycle: selected tap/channel carries (iv,qv), all else large decoys
    task automatic smp(input bit tap, input bit ch, input int iv, input int qv, input bit v);
        for (int c = 0; c < 2; c++) begin
            in_i[c] = 16'd25000; in_q[c] = -16'sd20000;
            out_i[c] = -16'sd22000; out_q[c] = 16'd27000;
        end
        in_vld = 1'b1; out_vld = 1'b1;
        if (tap) begin
            out_vld = v; out_i[ch] = iv[15:0]; out_q[ch] = qv[15:0];
        end else begin
            in_vld = v; in_i[ch] = iv[15:0]; in_q[ch] = qv[15:0];
        end
        if (v) begin
            exp_sum += longint'(iv) * iv + longint'(qv) * qv;
            exp_n++;
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_result();
        return 16'((exp_sum / exp_n) >> 16);
    endfunction

    task automatic push_exp();
        expq.push_back(exp_result());
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: each rising irq must match a queued expected result
    initial begin
        forever begin
            @(posedge irq);
            @(negedge clk);
            if (expq.size() == 0) begin
                chk("R8", "unexpected irq", 1, 0);
            end else begin
                chk("R6", "result at irq", rdata, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, rv); chk("R1", "ctrl reset", rv, 16'h0000);
        rd(2'd1, rv); chk("R1", "blklen reset", rv, 16'hFFFF);
        rd(2'd2, rv); chk("R1", "result reset", rv, 16'h0000);
        rd(2'd3, rv); chk("R1", "mask reset", rv, 16'h0000);
        chk("R1", "irq reset", irq, 0);

        // R2 R5: input tap ch0, 2 blocks of 4, gaps with valid low
        wr(2'd1, 16'd3);
        wr(2'd3, 16'h0020);
        start_meas(16'h0002);
        for (int k = 0; k < 8; k++) begin
            smp(1'b0, 1'b0, 1000, 1000, 1'b1);
            if (k % 3 == 0) smp(1'b0, 1'b0, 30000, 30000, 1'b0);
        end
        idle();
        push_exp();
        drain();
        chk("R8", "irq after done", irq, 1);
        rd(2'd0, rv); chk("R7", "count cleared", rv, 16'h0000);
        for (int k = 0; k < 3; k++) smp(1'b0, 1'b0, 20000, 20000, 1'b1);
        idle();
        repeat (80) @(negedge clk);
        rd(2'd2, rv); chk("R7", "result kept after extra samples", rv, 16'd30);

        // R3 R4: output tap ch1, 3 blocks of 5, varied samples
        wr(2'd1, 16'd4);
        start_meas(16'hC003);
        chk("R8", "irq cleared by ctrl write", irq, 0);
        for (int k = 0; k < 15; k++) begin
            smp(1'b1, 1'b1, 2000 + k * 700, -k * 900, 1'b1);
            if (k == 7) smp(1'b1, 1'b1, 32000, 32000, 1'b0);
        end
        idle();
        push_exp();
        drain();
        rd(2'd0, rv); chk("R7", "tap/channel kept", rv, 16'hC000);

        // R9: abort mid-run, restart on output ch0 with 1 block of 2
        wr(2'd1, 16'd1);
        start_meas(16'h0004);
        for (int k = 0; k < 3; k++) smp(1'b0, 1'b0, 30000, 30000, 1'b1);
        idle();
        start_meas(16'h4001);
        smp(1'b1, 1'b0, 5000, 5000, 1'b1);
        smp(1'b1, 1'b0, 5000, -5000, 1'b1);
        idle();
        push_exp();
        drain();
        repeat (80) @(negedge clk);
        chk("R9", "single completion", expq.size(), 0);

        // R6 full scale
        wr(2'd1, 16'd0);
        start_meas(16'h0001);
        smp(1'b0, 1'b0, -32768, -32768, 1'b1);
        idle();
        chk("R6", "full-scale expected", exp_result(), 16'h8000);
        push_exp();
        drain();

        // R8: only bit 5 of the mask drives irq
        wr(2'd3, 16'h0010);
        start_meas(16'h0001);
        smp(1'b0, 1'b0, 3000, 3000, 1'b1);
        idle();
        repeat (100) @(negedge clk);
        chk("R8", "irq with bit 5 clear", irq, 0);
        rd(2'd2, rv); chk("R6", "result without irq", rv, 16'd274);
        push_exp();
        wr(2'd3, 16'h0020);
        drain();

        // R2: zero count write starts nothing
        wr(2'd0, 16'h0000);
        chk("R8", "irq after zero write", irq, 0);
        for (int k = 0; k < 4; k++) smp(1'b0, 1'b0, 9000, 9000, 1'b1);
        idle();
        repeat (100) @(negedge clk);
        chk("R2", "no run after zero write", irq, 0);
        rd(2'd2, rv); chk("R2", "result unchanged", rv, 16'd274);

        // R10 R11: result write ignored, readback of others
        wr(2'd2, 16'h1234);
        rd(2'd2, rv); chk("R10", "result write ignored", rv, 16'd274);
        rd(2'd1, rv); chk("R10", "blklen readback", rv, 16'd0);
        rd(2'd3, rv); chk("R10", "mask readback", rv, 16'h0020);

        report();
    end

endmodule